// File: doc/BRIEF.md
# Capability Program Counter Sequencer

This block keeps the program counter as a bounded, tagged capability rather than a bare address. It holds four capability registers: the current code capability, the next one, the delayed one that a pending branch will install, and the exception return capability. Each fetch request is checked against the current code capability. The absolute fetch address is the capability base plus the offset program counter. The check reports either a clean fetch address or a fault with a two-bit cause.

The block also stages the capability registers around control transfers. A capability branch parks its target in the delayed register. Instruction advances move the next capability into the current one, and inside a delay slot they move the delayed capability into next. Exception entry saves the interrupted code capability, loads the kernel code capability into next and delayed, and pulses the handler vector. Exception return loads the saved capability into next and delayed.

Two flags, branch pending and call delay, are held in a four-state machine:
- SQ_IDLE: neither flag is set.
- SQ_BRANCH: only branch pending is set.
- SQ_CALL: only call delay is set.
- SQ_BRANCH_CALL: both flags are set.

The machine changes state in these ways:
- A branch request enters a state with branch pending set. It also sets call delay when the call qualifier is high.
- An advance clears branch pending.
- An advance outside a delay slot also clears call delay.
- Exception and return cycles hold the state.

Top module: `cpcs_seq`

Capability word layout, most significant bit first: `{tag[1], top[17], base[16], offset[16]}`, 50 bits in total. The reset (default) capability is tag 1, base 0, top 0x10000, offset 0.

## Requirements
- R1: After reset, all four capability outputs equal the default capability. `br_pending`, `call_delay`, `fetch_ok`, `fault_valid` and `vec_valid` are all 0.
- R2: In the cycle after a fetch request, `fetch_addr` is (current base + `pc_off`) truncated to 16 bits. `fetch_ok` is 1 when no fault applies.
- R3: If the full absolute address is not a multiple of 4, the fault cause is 0 (address error). This takes priority over every other cause, and `fetch_addr` carries the absolute address.
- R4: If the address is aligned and the current tag is 0, the fault cause is 1 (tag).
- R5: If the address is aligned and tagged, and absolute address + 4 is greater than top, the fault cause is 2 (length). Absolute address + 4 equal to top passes.
- R6: Every fault reports `fault_reg` = 0xFF. A fault is a one-cycle pulse and is never high together with `fetch_ok`.
- R7: A branch request loads `delayed_cap` with the target and `delayed_pc` with the target offset, and sets `br_pending`. When `cbr_call` is also high, it sets `call_delay`.
- R8: An advance copies next into current and clears `br_pending`. With `in_delay` high, next takes the delayed capability and `call_delay` is kept. With `in_delay` low, `call_delay` is cleared.
- R9: On exception entry with `exl` low, the saved capability is the current capability with its offset replaced by `pc_off`, provided base + `pc_off` ≤ top. Otherwise it is the capability {tag 0, top 0x10000, base 0, offset base+`pc_off`}.
- R10: On exception entry with `exl` high, the saved capability is unchanged.
- R11: Exception entry loads next and delayed from `kcc`. In the following cycle it pulses `vec_valid` with `vec_addr` = `kcc` base + VEC_OFFSET (default 0x0180).
- R12: Exception return loads next and delayed from the saved capability.
- R13: Exception entry outranks return, and both outrank branch and advance. In an exception or return cycle the current capability and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_off | input | 16 | Offset program counter |
| fetch_req | input | 1 | Request a fetch check this cycle |
| fetch_ok | output | 1 | Check passed (one-cycle pulse) |
| fetch_addr | output | 16 | Absolute fetch address |
| fault_valid | output | 1 | Fetch fault pulse |
| fault_cause | output | 2 | 0 address error, 1 tag, 2 length |
| fault_reg | output | 8 | Register number of the fault, 0xFF |
| advance | input | 1 | Instruction advance |
| in_delay | input | 1 | The advance is in a branch delay slot |
| cbr_req | input | 1 | Capability branch request |
| cbr_call | input | 1 | Branch is a call (sets call delay) |
| cbr_target | input | 50 | Branch target capability |
| exc_take | input | 1 | Exception entry strobe |
| exl | input | 1 | Exception-level bit |
| kcc | input | 50 | Kernel code capability |
| eret | input | 1 | Exception return strobe |
| vec_valid | output | 1 | Handler vector pulse |
| vec_addr | output | 16 | Handler vector address |
| pcc_cap | output | 50 | Current code capability |
| next_cap | output | 50 | Next code capability |
| delayed_cap | output | 50 | Delayed code capability |
| epcc_cap | output | 50 | Saved exception capability |
| delayed_pc | output | 16 | Offset of the last branch target |
| br_pending | output | 1 | Branch pending flag |
| call_delay | output | 1 | Call-delay flag |

## Verification
The assertions assume that strobes are only meaningful while reset is released. They also assume that `kcc` and the saved capability are stable inputs in the cycle an exception or return is taken. The assertions assume nothing about strobes being mutually exclusive, so simultaneous entry, return, branch and advance are resolved by the priority rule.

The bench drives every input away from the clock edge and loads each test capability through an exception with `exl` high followed by an advance. This keeps the saved capability untouched while the fetch sweeps run. The sweeps walk `pc_off` across each capability's range, so the misaligned, untagged, exact-fit and overrun cases all occur. Wrapping bases are included so the full-width absolute address is exercised.

// File: rtl/cpcs_pkg.sv
package cpcs_pkg;
    localparam int CAP_AW = 16;
    localparam int CAP_TW = CAP_AW + 1;

    typedef struct packed {
        logic              tag;
        logic [CAP_TW-1:0] top;
        logic [CAP_AW-1:0] base;
        logic [CAP_AW-1:0] offset;
    } cap_t;

    localparam int CAP_W = $bits(cap_t);

    typedef enum logic [1:0] {
        FC_ADDR = 2'd0,
        FC_TAG  = 2'd1,
        FC_LEN  = 2'd2
    } fault_cause_e;

    typedef enum logic [1:0] {
        SQ_IDLE        = 2'd0,
        SQ_BRANCH      = 2'd1,
        SQ_CALL        = 2'd2,
        SQ_BRANCH_CALL = 2'd3
    } seq_state_e;

    localparam logic [7:0] NO_REG = 8'hFF;

    function automatic cap_t cap_default();
        cap_t c;
        c.tag    = 1'b1;
        c.top    = CAP_TW'(1) << CAP_AW;
        c.base   = '0;
        c.offset = '0;
        return c;
    endfunction
endpackage

// File: rtl/cpcs_fetch_chk.sv
module cpcs_fetch_chk
    import cpcs_pkg::*;
#(
    parameter int FETCH_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [CAP_AW-1:0] pc_off,
    input  logic              cur_tag,
    input  logic [CAP_AW-1:0] cur_base,
    input  logic [CAP_TW-1:0] cur_top,
    output logic              fetch_ok,
    output logic [CAP_AW-1:0] fetch_addr,
    output logic              fault_valid,
    output logic [1:0]        fault_cause,
    output logic [7:0]        fault_reg
);
    localparam int ALW = $clog2(FETCH_BYTES);
    localparam logic [CAP_TW:0] STEP = (CAP_TW+1)'(FETCH_BYTES);

    logic [CAP_TW-1:0] abs_full;
    logic [CAP_TW:0]   end_full;
    logic              misaligned, overrun, any_fault;
    fault_cause_e      cause_d;

    always_comb begin
        abs_full   = {1'b0, cur_base} + {1'b0, pc_off};
        end_full   = {1'b0, abs_full} + STEP;
        misaligned = |abs_full[ALW-1:0];
        overrun    = end_full > {1'b0, cur_top};
        any_fault  = 1'b1;
        cause_d    = FC_ADDR;
        if (misaligned)    cause_d = FC_ADDR;
        else if (!cur_tag) cause_d = FC_TAG;
        else if (overrun)  cause_d = FC_LEN;
        else               any_fault = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ok    <= 1'b0;
            fault_valid <= 1'b0;
            fault_cause <= 2'd0;
            fault_reg   <= 8'd0;
            fetch_addr  <= '0;
        end else begin
            fetch_ok    <= fetch_req && !any_fault;
            fault_valid <= fetch_req && any_fault;
            fault_cause <= fetch_req ? cause_d : 2'd0;
            fault_reg   <= (fetch_req && any_fault) ? NO_REG : 8'd0;
            if (fetch_req) fetch_addr <= abs_full[CAP_AW-1:0];
        end
    end

    AST_FETCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_valid && fetch_ok)); // R6
    AST_FETCH_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid || fetch_ok) |-> $past(fetch_req)); // R2
    AST_FAULT_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fault_reg == NO_REG); // R6
    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (|fetch_addr[ALW-1:0])) |-> fault_cause == FC_ADDR); // R3
endmodule

// File: rtl/cpcs_cap_seq.sv
module cpcs_cap_seq
    import cpcs_pkg::*;
#(
    parameter logic [CAP_AW-1:0] VEC_OFFSET = 16'h0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAP_AW-1:0] pc_off,
    input  logic              advance,
    input  logic              in_delay,
    input  logic              cbr_req,
    input  logic              cbr_call,
    input  cap_t              cbr_target,
    input  logic              exc_take,
    input  logic              exl,
    input  cap_t              kcc,
    input  logic              eret,
    output cap_t              pcc_q,
    output cap_t              nxt_q,
    output cap_t              dly_q,
    output cap_t              epcc_q,
    output logic [CAP_AW-1:0] dly_pc_q,
    output logic              vec_valid,
    output logic [CAP_AW-1:0] vec_addr,
    output logic              br_pending,
    output logic              call_delay
);
    seq_state_e        state_q, state_d;
    logic              pend_c, call_c, pend_n, call_n;
    logic              normal_cycle;
    logic [CAP_TW-1:0] save_abs;
    cap_t              save_cap;

    assign normal_cycle = !exc_take && !eret;

    // flag state machine: next state
    always_comb begin
        pend_c = 1'b0;
        call_c = 1'b0;
        unique case (state_q)
            SQ_IDLE:        ;
            SQ_BRANCH:      pend_c = 1'b1;
            SQ_CALL:        call_c = 1'b1;
            SQ_BRANCH_CALL: begin pend_c = 1'b1; call_c = 1'b1; end
        endcase
        pend_n = pend_c;
        call_n = call_c;
        if (normal_cycle) begin
            if (advance) begin
                pend_n = 1'b0;
                if (!in_delay) call_n = 1'b0;
            end
            if (cbr_req) begin
                pend_n = 1'b1;
                if (cbr_call) call_n = 1'b1;
            end
        end
        unique case ({pend_n, call_n})
            2'b00: state_d = SQ_IDLE;
            2'b10: state_d = SQ_BRANCH;
            2'b01: state_d = SQ_CALL;
            2'b11: state_d = SQ_BRANCH_CALL;
        endcase
    end

    // flag state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // flag outputs
    always_comb begin
        br_pending = (state_q == SQ_BRANCH) || (state_q == SQ_BRANCH_CALL);
        call_delay = (state_q == SQ_CALL)   || (state_q == SQ_BRANCH_CALL);
    end

    // saved capability on exception entry
    always_comb begin
        save_abs = {1'b0, pcc_q.base} + {1'b0, pc_off};
        if (save_abs <= pcc_q.top) begin
            save_cap        = pcc_q;
            save_cap.offset = pc_off;
        end else begin
            save_cap.tag    = 1'b0;
            save_cap.top    = CAP_TW'(1) << CAP_AW;
            save_cap.base   = '0;
            save_cap.offset = save_abs[CAP_AW-1:0];
        end
    end

    // capability registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcc_q     <= cap_default();
            nxt_q     <= cap_default();
            dly_q     <= cap_default();
            epcc_q    <= cap_default();
            dly_pc_q  <= '0;
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= exc_take;
            if (exc_take) begin
                if (!exl) epcc_q <= save_cap;
                nxt_q    <= kcc;
                dly_q    <= kcc;
                vec_addr <= kcc.base + VEC_OFFSET;
            end else if (eret) begin
                nxt_q <= epcc_q;
                dly_q <= epcc_q;
            end else begin
                if (advance) begin
                    pcc_q <= nxt_q;
                    if (in_delay) nxt_q <= dly_q;
                end
                if (cbr_req) begin
                    dly_q    <= cbr_target;
                    dly_pc_q <= cbr_target.offset;
                end
            end
        end
    end

    AST_EXC_LOADS_KCC: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (nxt_q == $past(kcc)) && (dly_q == $past(kcc))); // R11
    AST_ERET_LOADS_EPCC: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_take) |=> (nxt_q == $past(epcc_q)) && (dly_q == $past(epcc_q))); // R12
    AST_ADV_MOVES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && normal_cycle) |=> pcc_q == $past(nxt_q)); // R8
    AST_EXL_HOLDS_EPCC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exl) |=> $stable(epcc_q)); // R10
    AST_TRAP_HOLDS_PCC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take || eret) |=> $stable(pcc_q) && $stable(br_pending) && $stable(call_delay)); // R13
    AST_BRANCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_req && normal_cycle) |=> br_pending); // R7
endmodule

// File: rtl/cpcs_seq.sv
module cpcs_seq
    import cpcs_pkg::*;
#(
    parameter logic [CAP_AW-1:0] VEC_OFFSET  = 16'h0180,
    parameter int                FETCH_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAP_AW-1:0] pc_off,
    input  logic              fetch_req,
    output logic              fetch_ok,
    output logic [CAP_AW-1:0] fetch_addr,
    output logic              fault_valid,
    output logic [1:0]        fault_cause,
    output logic [7:0]        fault_reg,
    input  logic              advance,
    input  logic              in_delay,
    input  logic              cbr_req,
    input  logic              cbr_call,
    input  logic [CAP_W-1:0]  cbr_target,
    input  logic              exc_take,
    input  logic              exl,
    input  logic [CAP_W-1:0]  kcc,
    input  logic              eret,
    output logic              vec_valid,
    output logic [CAP_AW-1:0] vec_addr,
    output logic [CAP_W-1:0]  pcc_cap,
    output logic [CAP_W-1:0]  next_cap,
    output logic [CAP_W-1:0]  delayed_cap,
    output logic [CAP_W-1:0]  epcc_cap,
    output logic [CAP_AW-1:0] delayed_pc,
    output logic              br_pending,
    output logic              call_delay
);
    cap_t pcc_c, nxt_c, dly_c, epcc_c, tgt_c, kcc_c;

    assign tgt_c = cap_t'(cbr_target);
    assign kcc_c = cap_t'(kcc);

    cpcs_cap_seq #(.VEC_OFFSET(VEC_OFFSET)) u_cap_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_off     (pc_off),
        .advance    (advance),
        .in_delay   (in_delay),
        .cbr_req    (cbr_req),
        .cbr_call   (cbr_call),
        .cbr_target (tgt_c),
        .exc_take   (exc_take),
        .exl        (exl),
        .kcc        (kcc_c),
        .eret       (eret),
        .pcc_q      (pcc_c),
        .nxt_q      (nxt_c),
        .dly_q      (dly_c),
        .epcc_q     (epcc_c),
        .dly_pc_q   (delayed_pc),
        .vec_valid  (vec_valid),
        .vec_addr   (vec_addr),
        .br_pending (br_pending),
        .call_delay (call_delay)
    );

    cpcs_fetch_chk #(.FETCH_BYTES(FETCH_BYTES)) u_fetch_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .pc_off      (pc_off),
        .cur_tag     (pcc_c.tag),
        .cur_base    (pcc_c.base),
        .cur_top     (pcc_c.top),
        .fetch_ok    (fetch_ok),
        .fetch_addr  (fetch_addr),
        .fault_valid (fault_valid),
        .fault_cause (fault_cause),
        .fault_reg   (fault_reg)
    );

    assign pcc_cap     = pcc_c;
    assign next_cap    = nxt_c;
    assign delayed_cap = dly_c;
    assign epcc_cap    = epcc_c;
endmodule

// File: tb/cpcs_seq_bench.sv
module cpcs_seq_bench;
    import cpcs_pkg::*;
    localparam int AW = CAP_AW;
    localparam logic [AW-1:0] VEC = 16'h0180;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, fetch_req, advance, in_delay, cbr_req, cbr_call, exc_take, exl, eret;
    logic [AW-1:0] pc_off;
    logic [CAP_W-1:0] cbr_target, kcc;
    logic fetch_ok, fault_valid, vec_valid, br_pending, call_delay;
    logic [AW-1:0] fetch_addr, vec_addr, delayed_pc;
    logic [1:0] fault_cause;
    logic [7:0] fault_reg;
    logic [CAP_W-1:0] pcc_cap, next_cap, delayed_cap, epcc_cap;

    int checks = 0;
    int errors = 0;

    cpcs_seq #(.VEC_OFFSET(VEC)) u_cpcs_seq (
        .clk(clk), .rst_n(rst_n), .pc_off(pc_off), .fetch_req(fetch_req),
        .fetch_ok(fetch_ok), .fetch_addr(fetch_addr), .fault_valid(fault_valid),
        .fault_cause(fault_cause), .fault_reg(fault_reg), .advance(advance),
        .in_delay(in_delay), .cbr_req(cbr_req), .cbr_call(cbr_call),
        .cbr_target(cbr_target), .exc_take(exc_take), .exl(exl), .kcc(kcc),
        .eret(eret), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .pcc_cap(pcc_cap), .next_cap(next_cap), .delayed_cap(delayed_cap),
        .epcc_cap(epcc_cap), .delayed_pc(delayed_pc), .br_pending(br_pending),
        .call_delay(call_delay)
    );

    function automatic logic [CAP_W-1:0] mk(input logic t, input logic [CAP_TW-1:0] tp,
                                            input logic [AW-1:0] b, input logic [AW-1:0] o);
        return {t, tp, b, o};
    endfunction

    localparam logic [CAP_W-1:0] DEF = {1'b1, 17'h10000, 16'h0, 16'h0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fetch_req = 0; advance = 0; in_delay = 0; cbr_req = 0; cbr_call = 0;
        exc_take = 0; exl = 0; eret = 0; pc_off = '0; cbr_target = '0; kcc = '0;
    endtask

    // place capability c in the current register without touching the saved one
    task automatic load_pcc(input logic [CAP_W-1:0] c);
        idle(); exc_take = 1; exl = 1; kcc = c; tick();
        idle(); advance = 1; tick();
        idle();
    endtask

    task automatic fetch_sweep(input logic t, input logic [CAP_TW-1:0] tp, input logic [AW-1:0] b);
        load_pcc(mk(t, tp, b, 16'h0));
        for (int p = 0; p < 48; p++) begin
            logic [CAP_TW-1:0] a;
            logic [CAP_TW:0] e;
            logic f;
            logic [1:0] c;
            a = {1'b0, b} + CAP_TW'(p);
            e = {1'b0, a} + 18'd4;
            f = 1'b1; c = 2'd0;
            if (a[1:0] != 2'b00) c = 2'd0;
            else if (!t) c = 2'd1;
            else if (e > {1'b0, tp}) c = 2'd2;
            else f = 1'b0;
            idle(); fetch_req = 1; pc_off = AW'(p); tick();
            idle();
            chk("R2 fetch_addr", 64'(fetch_addr), 64'(a[AW-1:0]));
            chk(f ? "R6 fault_valid" : "R2 fetch_ok", {62'd0, fault_valid, fetch_ok}, {62'd0, f, !f});
            if (f) begin
                chk(c == 2'd0 ? "R3 cause" : (c == 2'd1 ? "R4 cause" : "R5 cause"),
                    64'(fault_cause), 64'(c));
                chk("R6 fault_reg", 64'(fault_reg), 64'hFF);
            end
            tick();
            chk("R6 pulse cleared", {62'd0, fault_valid, fetch_ok}, 64'd0);
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CAP_W-1:0] t1, t2, k1, p1, ep;
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 pcc", 64'(pcc_cap), 64'(DEF));
        chk("R1 next", 64'(next_cap), 64'(DEF));
        chk("R1 delayed", 64'(delayed_cap), 64'(DEF));
        chk("R1 epcc", 64'(epcc_cap), 64'(DEF));
        chk("R1 flags/pulses", {59'd0, br_pending, call_delay, fetch_ok, fault_valid, vec_valid}, 64'd0);

        // R2..R6 fetch sweeps
        fetch_sweep(1'b1, 17'h00040, 16'h0000);
        fetch_sweep(1'b1, 17'h00028, 16'h0002);
        fetch_sweep(1'b0, 17'h00064, 16'h0008);
        fetch_sweep(1'b1, 17'h00020, 16'h0004);
        fetch_sweep(1'b1, 17'h10000, 16'hFFF8);

        // R7 branch with call
        t1 = mk(1'b1, 17'h00300, 16'h0200, 16'h0024);
        p1 = mk(1'b1, 17'h00100, 16'h0040, 16'h0000);
        load_pcc(p1);
        idle(); cbr_req = 1; cbr_call = 1; cbr_target = t1; tick(); idle();
        chk("R7 delayed", 64'(delayed_cap), 64'(t1));
        chk("R7 delayed_pc", 64'(delayed_pc), 64'h24);
        chk("R7 flags", {62'd0, br_pending, call_delay}, 64'd3);
        chk("R7 pcc unchanged", 64'(pcc_cap), 64'(p1));
        // R8 advance in delay slot
        idle(); advance = 1; in_delay = 1; tick(); idle();
        chk("R8 pcc from next", 64'(pcc_cap), 64'(p1));
        chk("R8 next from delayed", 64'(next_cap), 64'(t1));
        chk("R8 flags in slot", {62'd0, br_pending, call_delay}, 64'd1);
        // R8 advance outside slot
        idle(); advance = 1; tick(); idle();
        chk("R8 pcc takes target", 64'(pcc_cap), 64'(t1));
        chk("R8 call cleared", {62'd0, br_pending, call_delay}, 64'd0);
        // R7 branch without call
        t2 = mk(1'b1, 17'h00500, 16'h0400, 16'h0010);
        idle(); cbr_req = 1; cbr_target = t2; tick(); idle();
        chk("R7 plain branch flags", {62'd0, br_pending, call_delay}, 64'd2);
        chk("R7 delayed_pc plain", 64'(delayed_pc), 64'h10);

        // R9 / R11 exception entry sweep
        p1 = mk(1'b1, 17'h00040, 16'h0010, 16'h0000);
        k1 = mk(1'b1, 17'h09000, 16'h8000, 16'h0000);
        load_pcc(p1);
        for (int p = 0; p < 53; p++) begin
            logic [CAP_TW-1:0] a;
            a = 17'h10 + CAP_TW'(p);
            if (a <= 17'h40) ep = mk(1'b1, 17'h00040, 16'h0010, AW'(p));
            else ep = mk(1'b0, 17'h10000, 16'h0, a[AW-1:0]);
            idle(); exc_take = 1; exl = 0; kcc = k1; pc_off = AW'(p); tick(); idle();
            chk("R9 epcc", 64'(epcc_cap), 64'(ep));
            chk("R11 next", 64'(next_cap), 64'(k1));
            chk("R11 delayed", 64'(delayed_cap), 64'(k1));
            chk("R11 vector", {47'd0, vec_valid, vec_addr}, {47'd0, 1'b1, 16'h8000 + VEC});
            chk("R13 pcc held", 64'(pcc_cap), 64'(p1));
        end
        tick();
        chk("R11 vector pulse ends", 64'(vec_valid), 64'd0);

        // R10 exl high keeps epcc
        idle(); exc_take = 1; exl = 1; kcc = DEF; pc_off = 16'h4; tick(); idle();
        chk("R10 epcc kept", 64'(epcc_cap), 64'(ep));
        chk("R10 next loaded", 64'(next_cap), 64'(DEF));

        // R12 return
        idle(); eret = 1; tick(); idle();
        chk("R12 next", 64'(next_cap), 64'(ep));
        chk("R12 delayed", 64'(delayed_cap), 64'(ep));

        // R13 priorities
        idle(); cbr_req = 1; cbr_call = 1; cbr_target = t1; tick(); idle();
        idle(); exc_take = 1; exl = 1; eret = 1; cbr_req = 1; cbr_target = t2;
        advance = 1; kcc = k1; tick(); idle();
        chk("R13 exc wins next", 64'(next_cap), 64'(k1));
        chk("R13 exc wins delayed", 64'(delayed_cap), 64'(k1));
        chk("R13 pcc held", 64'(pcc_cap), 64'(p1));
        chk("R13 flags held", {62'd0, br_pending, call_delay}, 64'd3);
        chk("R13 delayed_pc held", 64'(delayed_pc), 64'h24);
        idle(); eret = 1; cbr_req = 1; cbr_target = t2; advance = 1; tick(); idle();
        chk("R13 eret wins next", 64'(next_cap), 64'(ep));
        chk("R13 eret wins delayed", 64'(delayed_cap), 64'(ep));
        chk("R13 eret pcc held", 64'(pcc_cap), 64'(p1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule